// File: doc/BRIEF.md
# Per-CPU Interrupt Interface

This block is the part of an interrupt controller that belongs to a single processor. Each cycle the distributor offers it one candidate interrupt: a valid flag, an ID and a priority. The block decides whether that candidate may interrupt the processor and drives a registered request line. Software talks to it through four word registers: an enable bit, a priority mask, an acknowledge register and an end-of-interrupt register. A read of the end-of-interrupt register returns the running priority.

Every processor uses the same register offsets. The bus carries the number of the processor that issues each access, and an instance answers only accesses tagged with its own number. When an acknowledge read takes the candidate, the interrupt becomes active. The block records its ID and priority in a small nesting table, and the lowest priority value in that table is the running priority. A later candidate can interrupt the processor only if its priority value is strictly below both the mask and the running priority. A write to end-of-interrupt removes the named ID from the table, and the block passes the retirement on to the distributor. IDs 0 to 31 arrive already banked for this processor and are handled like any other ID. An acknowledge read that cannot take the candidate returns a reserved spurious ID, which tells software to stop servicing.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the enable bit is 0, the mask is 0, the running priority reads 255, the request line is low and no response or pulse is given.
- R2: Offset 0 holds the enable bit in data bit 0. Reads return it with all other bits zero. While it is 0 the request line stays low.
- R3: Offset 1 holds an 8-bit priority mask in data bits 7:0. A candidate qualifies only if its priority is numerically strictly below the mask.
- R4: The request line is high one cycle after a cycle in which all of these hold: enable is set, the candidate is valid, the candidate's priority is below both the mask and the running priority, and the nesting table is not full.
- R5: A read of offset 2 in a cycle where the R4 condition holds does three things. It returns the candidate ID in bits 9:0 with the upper bits zero. It pulses ack_valid with ack_id equal to that ID in the following cycle. It makes the candidate's priority the running priority.
- R6: A read of offset 2 when the R4 condition fails returns the spurious ID 1023, gives no acknowledge pulse and changes no state.
- R7: A write of an ID to offset 3 retires that ID when it is active. The block then pulses eoi_valid with eoi_id one cycle later, and the running priority becomes the lowest priority of the entries still active. An ID that is not active gives no pulse and no change.
- R8: A candidate whose priority equals the running priority neither raises the request line nor is acknowledged.
- R9: Up to NEST interrupts (4 by default) can be active at once. While all NEST are active, the request line stays low and acknowledge returns 1023.
- R10: A read of offset 3 returns the running priority, or 255 when nothing is active.
- R11: An access whose processor number differs from CPU_IDX gets no read response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_cpu | input | CPU_W | Number of the processor issuing the access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word offset: 0 enable, 1 mask, 2 acknowledge, 3 end-of-interrupt / running priority |
| bus_wdata | input | DATA_W | Write data |
| bus_rvalid | output | 1 | Read response valid, one cycle after the read |
| bus_rdata | output | DATA_W | Read response data |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | ID_W | Candidate interrupt ID |
| cand_prio | input | PRIO_W | Candidate priority, lower value is more urgent |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | Pulse: candidate taken, distributor moves it from pending to active |
| ack_id | output | ID_W | ID taken |
| eoi_valid | output | 1 | Pulse: active ID retired |
| eoi_id | output | ID_W | ID retired |

## Verification
Every result is registered once. The request line follows its inputs by one cycle. A read response and the acknowledge pulse appear in the cycle after the read. The end-of-interrupt pulse appears in the cycle after the write. A change to the running priority reaches the request line one further cycle later. The bench drives inputs on the falling edge. Its reference model updates on the rising edge from the inputs that are held there and is compared with the outputs on the next falling edge. The directed checks wait two falling edges after any change before they look at the request line.

// File: rtl/cpuif_pkg.sv
// Shared definitions for the per-CPU interrupt interface.
package cpuif_pkg;
    // Word offsets of the software-visible registers.
    typedef enum logic [1:0] {
        OFS_ENABLE = 2'd0,
        OFS_MASK   = 2'd1,
        OFS_ACK    = 2'd2,
        OFS_EOI    = 2'd3
    } reg_ofs_e;
endpackage

// File: rtl/cpuif_regs.sv
// Holds the interface enable bit and the priority mask.
// Assumes the caller decodes the write strobes and allows at most one per cycle.
module cpuif_regs #(
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_enable,
    input  logic              wr_mask,
    input  logic              wdata_en,
    input  logic [PRIO_W-1:0] wdata_mask,
    output logic              enable,
    output logic [PRIO_W-1:0] mask
);
    // Capture the enable bit on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= 1'b0;
        else if (wr_enable)
            enable <= wdata_en;
    end

    // Capture the priority mask on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (wr_mask)
            mask <= wdata_mask;
    end
endmodule

// File: rtl/cpuif_active.sv
// Nesting table of active interrupts. It gives the running priority (the lowest
// value held, all ones when the table is empty), a full flag and an ID-match test.
// Assumes push and pop never occur in the same cycle and that the caller
// never pushes while the table is full.
module cpuif_active #(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int NEST   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop_req,
    input  logic [ID_W-1:0]   pop_id,
    output logic              pop_hit,
    output logic              full,
    output logic [PRIO_W-1:0] running
);
    localparam int IDX_W = (NEST > 1) ? $clog2(NEST) : 1;

    logic [NEST-1:0]   slot_v;
    logic [ID_W-1:0]   slot_id [NEST];
    logic [PRIO_W-1:0] slot_pr [NEST];
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  hit_idx;

    // Find the lowest free slot and the lowest slot that holds pop_id.
    always_comb begin
        free_idx = '0;
        hit_idx  = '0;
        pop_hit  = 1'b0;
        for (int i = NEST - 1; i >= 0; i--) begin
            if (!slot_v[i])
                free_idx = IDX_W'(i);
            if (slot_v[i] && slot_id[i] == pop_id) begin
                hit_idx = IDX_W'(i);
                pop_hit = 1'b1;
            end
        end
    end

    assign full = &slot_v;

    // Running priority is the minimum over the occupied slots.
    always_comb begin
        running = '1;
        for (int i = 0; i < NEST; i++)
            if (slot_v[i] && slot_pr[i] < running)
                running = slot_pr[i];
    end

    for (genvar g = 0; g < NEST; g++) begin : g_slot
        // Fill this slot on push, empty it on a matching pop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_v[g]  <= 1'b0;
                slot_id[g] <= '0;
                slot_pr[g] <= '0;
            end else if (push && !full && free_idx == IDX_W'(g)) begin
                slot_v[g]  <= 1'b1;
                slot_id[g] <= push_id;
                slot_pr[g] <= push_prio;
            end else if (pop_req && pop_hit && hit_idx == IDX_W'(g)) begin
                slot_v[g]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cpuif_gate.sv
// Decides whether the current candidate may interrupt the processor.
// Purely combinational. All of its inputs come from registers or the distributor.
module cpuif_gate #(
    parameter int PRIO_W = 8
) (
    input  logic              enable,
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] mask,
    input  logic [PRIO_W-1:0] running,
    input  logic              full,
    output logic              eligible
);
    // Both comparisons are strict: an equal value is filtered out.
    always_comb begin
        eligible = enable && cand_valid && !full
                && (cand_prio < mask) && (cand_prio < running);
    end
endmodule

// File: rtl/cpu_irq_iface.sv
// One processor's interrupt interface. It decodes the register accesses tagged
// for CPU_IDX, gates the distributor's candidate, registers the request line,
// and passes acknowledge and end-of-interrupt events back to the distributor.
// Assumes at most one register access per cycle.
module cpu_irq_iface
    import cpuif_pkg::*;
#(
    parameter int ID_W    = 10,
    parameter int PRIO_W  = 8,
    parameter int NEST    = 4,
    parameter int CPU_W   = 2,
    parameter int CPU_IDX = 0,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic [CPU_W-1:0]  bus_cpu,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    output logic              irq_o,
    output logic              ack_valid,
    output logic [ID_W-1:0]   ack_id,
    output logic              eoi_valid,
    output logic [ID_W-1:0]   eoi_id
);
    localparam logic [ID_W-1:0] SPURIOUS_ID = '1;

    logic              own, rd, wr;
    logic              ctrl_en;
    logic [PRIO_W-1:0] pmask;
    logic [PRIO_W-1:0] running;
    logic              full, pop_hit, eligible;
    logic              ack_take, eoi_req;
    logic [DATA_W-1:0] rd_mux;

    // Decode an access aimed at this processor's instance.
    always_comb begin
        own      = bus_sel && (bus_cpu == CPU_W'(CPU_IDX));
        rd       = own && !bus_wr;
        wr       = own && bus_wr;
        ack_take = rd && (bus_addr == OFS_ACK) && eligible;
        eoi_req  = wr && (bus_addr == OFS_EOI);
    end

    cpuif_regs #(.PRIO_W(PRIO_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_enable  (wr && bus_addr == OFS_ENABLE),
        .wr_mask    (wr && bus_addr == OFS_MASK),
        .wdata_en   (bus_wdata[0]),
        .wdata_mask (bus_wdata[PRIO_W-1:0]),
        .enable     (ctrl_en),
        .mask       (pmask)
    );

    cpuif_active #(.ID_W(ID_W), .PRIO_W(PRIO_W), .NEST(NEST)) u_active (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_take),
        .push_id   (cand_id),
        .push_prio (cand_prio),
        .pop_req   (eoi_req),
        .pop_id    (bus_wdata[ID_W-1:0]),
        .pop_hit   (pop_hit),
        .full      (full),
        .running   (running)
    );

    cpuif_gate #(.PRIO_W(PRIO_W)) u_gate (
        .enable     (ctrl_en),
        .cand_valid (cand_valid),
        .cand_prio  (cand_prio),
        .mask       (pmask),
        .running    (running),
        .full       (full),
        .eligible   (eligible)
    );

    // Select the read data for the addressed register.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFS_ENABLE: rd_mux[0] = ctrl_en;
            OFS_MASK:   rd_mux[PRIO_W-1:0] = pmask;
            OFS_ACK:    rd_mux[ID_W-1:0] = eligible ? cand_id : SPURIOUS_ID;
            default:    rd_mux[PRIO_W-1:0] = running;
        endcase
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd;
            bus_rdata  <= rd ? rd_mux : '0;
        end
    end

    // Register the request line and the events sent back to the distributor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            ack_valid <= 1'b0;
            ack_id    <= '0;
            eoi_valid <= 1'b0;
            eoi_id    <= '0;
        end else begin
            irq_o     <= eligible;
            ack_valid <= ack_take;
            ack_id    <= ack_take ? cand_id : '0;
            eoi_valid <= eoi_req && pop_hit;
            eoi_id    <= (eoi_req && pop_hit) ? bus_wdata[ID_W-1:0] : '0;
        end
    end
endmodule

// File: rtl/cpu_irq_iface_chk.sv
// Property checker for cpu_irq_iface. It is attached by the bind below and
// watches ports together with the enable, mask, running priority and full state.
module cpu_irq_iface_chk #(
    parameter int ID_W    = 10,
    parameter int PRIO_W  = 8,
    parameter int CPU_W   = 2,
    parameter int CPU_IDX = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic [CPU_W-1:0]  bus_cpu,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic              bus_rvalid,
    input logic [PRIO_W-1:0] cand_prio,
    input logic              irq_o,
    input logic              ack_valid,
    input logic              eoi_valid,
    input logic              ctrl_en,
    input logic [PRIO_W-1:0] pmask,
    input logic [PRIO_W-1:0] running,
    input logic              full
);
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(ctrl_en)); // R2
    AST_IRQ_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(cand_prio) < $past(pmask))); // R3
    AST_IRQ_PREEMPTS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(cand_prio) < $past(running))); // R8
    AST_ACK_SETS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (running <= $past(cand_prio))); // R5
    AST_ACK_NOT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> !$past(full)); // R9
    AST_EOI_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(bus_sel && bus_wr && bus_addr == 2'd3)); // R7
    AST_RESP_OWN_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_sel && !bus_wr && bus_cpu == CPU_W'(CPU_IDX))); // R11
endmodule

bind cpu_irq_iface cpu_irq_iface_chk #(
    .ID_W(ID_W), .PRIO_W(PRIO_W), .CPU_W(CPU_W), .CPU_IDX(CPU_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_cpu    (bus_cpu),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .cand_prio  (cand_prio),
    .irq_o      (irq_o),
    .ack_valid  (ack_valid),
    .eoi_valid  (eoi_valid),
    .ctrl_en    (ctrl_en),
    .pmask      (pmask),
    .running    (running),
    .full       (full)
);

// File: tb/cpu_irq_iface_test.sv
// Bench: a behavioural reference model compared on every clock, plus directed checks.
module cpu_irq_iface_test;
    localparam int NEST = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic [1:0]  bus_cpu = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [7:0]  cand_prio = '0;
    logic        irq_o, ack_valid, eoi_valid;
    logic [9:0]  ack_id, eoi_id;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cpu_irq_iface uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_cpu(bus_cpu),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .irq_o(irq_o), .ack_valid(ack_valid), .ack_id(ack_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_en, m_mask;
    int q_id[$];
    int q_pr[$];
    int e_irq, e_rv, e_rd, e_ackv, e_ackid, e_eoiv, e_eoiid;

    function automatic int m_running();
        int r = 255;
        foreach (q_pr[i]) if (q_pr[i] < r) r = q_pr[i];
        return r;
    endfunction

    always @(posedge clk) begin
        int run, elig, hit;
        if (!rst_n) begin
            m_en = 0; m_mask = 0; q_id.delete(); q_pr.delete();
            e_irq = 0; e_rv = 0; e_rd = 0; e_ackv = 0; e_ackid = 0; e_eoiv = 0; e_eoiid = 0;
        end else begin
            run  = m_running();
            elig = (m_en == 1 && cand_valid && int'(cand_prio) < m_mask
                    && int'(cand_prio) < run && q_id.size() < NEST) ? 1 : 0;
            e_irq = elig; e_rv = 0; e_rd = 0; e_ackv = 0; e_ackid = 0; e_eoiv = 0; e_eoiid = 0;
            if (bus_sel && bus_cpu == 2'd0) begin
                if (bus_wr) begin
                    if (bus_addr == 2'd0) m_en = int'(bus_wdata[0]);
                    else if (bus_addr == 2'd1) m_mask = int'(bus_wdata[7:0]);
                    else if (bus_addr == 2'd3) begin
                        hit = -1;
                        foreach (q_id[i]) if (hit < 0 && q_id[i] == int'(bus_wdata[9:0])) hit = i;
                        if (hit >= 0) begin
                            q_id.delete(hit); q_pr.delete(hit);
                            e_eoiv = 1; e_eoiid = int'(bus_wdata[9:0]);
                        end
                    end
                end else begin
                    e_rv = 1;
                    case (bus_addr)
                        2'd0: e_rd = m_en;
                        2'd1: e_rd = m_mask;
                        2'd2: if (elig == 1) begin
                                  e_rd = int'(cand_id); e_ackv = 1; e_ackid = int'(cand_id);
                                  q_id.push_back(int'(cand_id)); q_pr.push_back(int'(cand_prio));
                              end else e_rd = 1023;
                        default: e_rd = run;
                    endcase
                end
            end
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R4 irq_o", int'(irq_o), e_irq);
            chk("R11 rvalid", int'(bus_rvalid), e_rv);
            if (e_rv == 1) chk("R5 rdata", int'(bus_rdata), e_rd);
            chk("R5 ack_valid", int'(ack_valid), e_ackv);
            if (e_ackv == 1) chk("R5 ack_id", int'(ack_id), e_ackid);
            chk("R7 eoi_valid", int'(eoi_valid), e_eoiv);
            if (e_eoiv == 1) chk("R7 eoi_id", int'(eoi_id), e_eoiid);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- directed stimulus ----------------
    int last_rv, last_ackv, last_eoiv, last_eoiid;

    task automatic bus_write(int cpu, int addr, int data);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_cpu = 2'(cpu); bus_addr = 2'(addr); bus_wdata = 32'(data);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_cpu = '0;
        last_eoiv = int'(eoi_valid); last_eoiid = int'(eoi_id);
    endtask

    task automatic bus_read(int cpu, int addr, output int data);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_cpu = 2'(cpu); bus_addr = 2'(addr);
        @(negedge clk);
        bus_sel = 0; bus_cpu = '0;
        data = int'(bus_rdata); last_rv = int'(bus_rvalid); last_ackv = int'(ack_valid);
    endtask

    task automatic offer(int v, int id, int pr);
        @(negedge clk);
        cand_valid = v[0]; cand_id = 10'(id); cand_prio = 8'(pr);
        repeat (2) @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        @(negedge clk);
        chk("R1 irq after reset", int'(irq_o), 0);
        bus_read(0, 0, d); chk("R1 enable reset", d, 0);
        bus_read(0, 1, d); chk("R1 mask reset", d, 0);
        bus_read(0, 3, d); chk("R1 running reset", d, 255);

        bus_write(0, 1, 32'h0000_01F0);
        bus_write(0, 0, 32'h0000_0003);
        bus_read(0, 0, d); chk("R2 enable readback", d, 1);
        bus_read(0, 1, d); chk("R3 mask readback", d, 'hF0);

        offer(1, 40, 'h80); chk("R4 irq raised", int'(irq_o), 1);
        offer(1, 40, 'hF0); chk("R3 equal to mask filtered", int'(irq_o), 0);
        offer(1, 40, 'hEF); chk("R3 just below mask", int'(irq_o), 1);

        bus_write(0, 0, 0); settle();
        chk("R2 irq when disabled", int'(irq_o), 0);
        bus_read(0, 2, d); chk("R6 spurious when disabled", d, 1023);
        chk("R6 no ack pulse", last_ackv, 0);
        bus_write(0, 0, 1);

        offer(1, 40, 'hA0);
        bus_read(0, 2, d); chk("R5 ack id", d, 40);
        chk("R5 ack pulse", last_ackv, 1);
        bus_read(0, 3, d); chk("R10 running after ack", d, 'hA0);
        settle(); chk("R8 equal running no irq", int'(irq_o), 0);
        offer(1, 41, 'hA0);
        bus_read(0, 2, d); chk("R8 equal running spurious", d, 1023);

        offer(1, 42, 'h50); chk("R4 preempt irq", int'(irq_o), 1);
        bus_read(0, 2, d); chk("R5 nested ack", d, 42);
        offer(1, 43, 'h30); bus_read(0, 2, d); chk("R5 third ack", d, 43);
        offer(1, 44, 'h10); bus_read(0, 2, d); chk("R5 fourth ack", d, 44);
        offer(1, 45, 'h05); chk("R9 full no irq", int'(irq_o), 0);
        bus_read(0, 2, d); chk("R9 full spurious", d, 1023);

        bus_write(0, 3, 99); chk("R7 unknown id no pulse", last_eoiv, 0);
        bus_read(0, 3, d); chk("R7 running unchanged", d, 'h10);
        bus_write(0, 3, 44); chk("R7 eoi pulse", last_eoiv, 1);
        chk("R7 eoi id", last_eoiid, 44);
        bus_read(0, 3, d); chk("R7 running restored", d, 'h30);
        bus_write(0, 3, 40);
        bus_read(0, 3, d); chk("R7 out-of-order retire", d, 'h30);
        settle(); chk("R4 irq after retire", int'(irq_o), 1);

        bus_write(1, 0, 0);
        bus_read(0, 0, d); chk("R11 foreign write ignored", d, 1);
        bus_read(1, 0, d); chk("R11 foreign read no response", last_rv, 0);
        bus_write(1, 3, 43);
        bus_read(0, 3, d); chk("R11 foreign eoi ignored", d, 'h30);

        offer(1, 0, 'h01);
        bus_read(0, 2, d); chk("R5 banked id 0", d, 0);
        offer(0, 7, 'h01);
        bus_read(0, 2, d); chk("R6 no candidate spurious", d, 1023);
        settle();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule